// File: doc/BRIEF.md
# Inclusive Last-Level Cache Snoop Filter Controller

This block sits in front of the tag store of a shared last-level cache that four cores use. The cache is inclusive: any line held in a core's private caches is also present in the shared cache. For every resident line the controller keeps one presence bit per core. A bit is set when that core may hold a copy of the line. The controller uses these presence bits to decide how each incoming request is handled. A request that misses goes to memory without touching any core. A request that hits snoops only the cores whose presence bits call for it. When a line is displaced, the cores that may still hold the old line receive back-invalidate snoops, so that inclusion holds.

A core presents a line address, its core number and an ownership flag. The flag separates a plain read from a read-for-ownership. The controller handles one request at a time and raises `busy` until that request is finished. A request can finish with a snoop round, a back-invalidate round followed by a memory fill, a memory fill alone, or nothing at all. When the request completes, `done` pulses for one cycle. The tag store is a small direct-mapped array built from registers. The low address bits select the set.

Top module: `incl_snoop_ctrl`

## Requirements
- R1: After reset, `busy`, `snp_valid`, `mem_req` and `done` are all low.
- R2: A miss whose set holds no line marked in any core pulses `mem_req` with the request address one cycle after acceptance and issues no snoop. `mem_fill` then completes the request: `done` pulses in the cycle after it.
- R3: A hit where no core other than the requester has its presence bit set (all bits clear included) completes with `done` one cycle after acceptance, with no snoop and no memory request.
- R4: A plain read (`req_own`=0) that hits a line whose only set bit belongs to another core issues one non-invalidating snoop (`snp_inval`=0). Its mask bit i (bit i = core i) names that core alone.
- R5: A plain read that hits a line with two or more presence bits set completes with no snoop, because such a line cannot be dirty in any core.
- R6: A read-for-ownership (`req_own`=1) that hits sends an invalidating snoop (`snp_inval`=1) to every other core whose bit is set, and never to the requester. Afterwards only the requester's bit remains set.
- R7: A miss whose set holds a valid line with presence bits set first sends an invalidating snoop for the victim's address to exactly those cores. Only after all of them respond does it raise `mem_req` for the new address.
- R8: `busy` stays high until every targeted core has answered on `snp_resp` (bit i = core i) and any memory fill has arrived. A request presented while `busy` is high is dropped.
- R9: When a request completes, the requester's presence bit is recorded, and the line takes the requested address. Line address bits [2:0] select one of 8 sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_core | input | 2 | Requesting core number |
| req_addr | input | 12 | Line address |
| req_own | input | 1 | 1 = read-for-ownership, 0 = read |
| busy | output | 1 | A request is in flight |
| snp_valid | output | 1 | One-cycle snoop issue pulse |
| snp_mask | output | 4 | Target cores, bit i = core i |
| snp_addr | output | 12 | Line address being snooped |
| snp_inval | output | 1 | 1 = invalidate, 0 = probe for data |
| snp_resp | input | 4 | Per-core snoop response pulses |
| mem_req | output | 1 | One-cycle memory read pulse |
| mem_addr | output | 12 | Memory read address |
| mem_fill | input | 1 | Memory data returned |
| done | output | 1 | One-cycle completion pulse |

## Verification
The decision logic is driven by a series of accesses to one line, so that its presence vector passes through these states: empty, one other core, two or more cores, requester only, and finally displaced by a conflicting address. Each stage separates a correct presence decision from one that snoops too much or too little. Plain reads are set against read-for-ownership on the same vector, which distinguishes probe from invalidate and shows whether the requester's bit is kept out of the mask. A response that covers only part of the targets, and requests offered while the block is busy, show that completion waits for every answer and that no extra request is accepted.

// File: rtl/isc_pkg.sv
package isc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SNOOP = 2'd1,
        ST_EVICT = 2'd2,
        ST_MEM   = 2'd3
    } isc_state_e;
endpackage

// File: rtl/isc_tag_array.sv
module isc_tag_array #(
    parameter int SETS      = 8,
    parameter int TAG_W     = 9,
    parameter int NUM_CORES = 4,
    localparam int IDX_W    = $clog2(SETS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic                 rd_valid,
    output logic [TAG_W-1:0]     rd_tag,
    output logic [NUM_CORES-1:0] rd_cv,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [TAG_W-1:0]     wr_tag,
    input  logic [NUM_CORES-1:0] wr_cv
);
    logic                 valid_q [SETS];
    logic [TAG_W-1:0]     tag_q   [SETS];
    logic [NUM_CORES-1:0] cv_q    [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[s] <= 1'b0;
                tag_q[s]   <= '0;
                cv_q[s]    <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(s))) begin
                valid_q[s] <= 1'b1;
                tag_q[s]   <= wr_tag;
                cv_q[s]    <= wr_cv;
            end
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_cv    = cv_q[rd_idx];
endmodule

// File: rtl/isc_snoop_plan.sv
module isc_snoop_plan #(
    parameter int NUM_CORES = 4,
    localparam int CORE_W   = $clog2(NUM_CORES)
) (
    input  logic [NUM_CORES-1:0] cv,
    input  logic [CORE_W-1:0]    req_core,
    input  logic                 own,
    output logic [NUM_CORES-1:0] req_oh,
    output logic [NUM_CORES-1:0] snoop_mask,
    output logic                 snoop_inval,
    output logic [NUM_CORES-1:0] next_cv
);
    logic [NUM_CORES-1:0] others;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_oh
        assign req_oh[c] = (req_core == CORE_W'(c));
    end

    assign others = cv & ~req_oh;

    always_comb begin
        if (own) begin
            snoop_mask  = others;
            snoop_inval = 1'b1;
            next_cv     = req_oh;
        end else begin
            snoop_mask  = (($countones(cv) == 1) && (others != '0)) ? others : '0;
            snoop_inval = 1'b0;
            next_cv     = cv | req_oh;
        end
    end
endmodule

// File: rtl/incl_snoop_ctrl.sv
module incl_snoop_ctrl
    import isc_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 12,
    parameter int SETS      = 8,
    localparam int CORE_W   = $clog2(NUM_CORES),
    localparam int IDX_W    = $clog2(SETS),
    localparam int TAG_W    = ADDR_W - IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [CORE_W-1:0]    req_core,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_own,
    output logic                 busy,
    output logic                 snp_valid,
    output logic [NUM_CORES-1:0] snp_mask,
    output logic [ADDR_W-1:0]    snp_addr,
    output logic                 snp_inval,
    input  logic [NUM_CORES-1:0] snp_resp,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic                 mem_fill,
    output logic                 done
);
    typedef struct packed {
        isc_state_e           state;
        logic [CORE_W-1:0]    core;
        logic [ADDR_W-1:0]    addr;
        logic [NUM_CORES-1:0] pend;
        logic [NUM_CORES-1:0] upd_cv;
        logic                 snp_valid;
        logic [NUM_CORES-1:0] snp_mask;
        logic [ADDR_W-1:0]    snp_addr;
        logic                 snp_inval;
        logic                 mem_req;
        logic                 done;
    } ctrl_t;

    ctrl_t d, q;

    logic                 rd_valid;
    logic [TAG_W-1:0]     rd_tag;
    logic [NUM_CORES-1:0] rd_cv;
    logic                 wr_en;
    logic [IDX_W-1:0]     wr_idx;
    logic [TAG_W-1:0]     wr_tag;
    logic [NUM_CORES-1:0] wr_cv;

    logic [NUM_CORES-1:0] req_oh, plan_mask, plan_cv;
    logic                 plan_inval;
    logic                 accept, hit, victim_live;
    logic [NUM_CORES-1:0] pend_left;

    isc_tag_array #(.SETS(SETS), .TAG_W(TAG_W), .NUM_CORES(NUM_CORES)) i_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (req_addr[IDX_W-1:0]),
        .rd_valid(rd_valid),
        .rd_tag  (rd_tag),
        .rd_cv   (rd_cv),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_tag  (wr_tag),
        .wr_cv   (wr_cv)
    );

    isc_snoop_plan #(.NUM_CORES(NUM_CORES)) i_plan (
        .cv         (rd_cv),
        .req_core   (req_core),
        .own        (req_own),
        .req_oh     (req_oh),
        .snoop_mask (plan_mask),
        .snoop_inval(plan_inval),
        .next_cv    (plan_cv)
    );

    assign accept      = req_valid && (q.state == ST_IDLE);
    assign hit         = rd_valid && (rd_tag == req_addr[ADDR_W-1:IDX_W]);
    assign victim_live = rd_valid && (rd_cv != '0);
    assign pend_left   = q.pend & ~snp_resp;

    always_comb begin
        d           = q;
        d.snp_valid = 1'b0;
        d.mem_req   = 1'b0;
        d.done      = 1'b0;
        wr_en       = 1'b0;
        wr_idx      = q.addr[IDX_W-1:0];
        wr_tag      = q.addr[ADDR_W-1:IDX_W];
        wr_cv       = q.upd_cv;

        unique case (q.state)
            ST_IDLE: begin
                if (accept) begin
                    d.core = req_core;
                    d.addr = req_addr;
                    if (hit) begin
                        d.upd_cv = plan_cv;
                        if (plan_mask != '0) begin
                            d.state     = ST_SNOOP;
                            d.pend      = plan_mask;
                            d.snp_valid = 1'b1;
                            d.snp_mask  = plan_mask;
                            d.snp_addr  = req_addr;
                            d.snp_inval = plan_inval;
                        end else begin
                            wr_en  = 1'b1;
                            wr_idx = req_addr[IDX_W-1:0];
                            wr_tag = req_addr[ADDR_W-1:IDX_W];
                            wr_cv  = plan_cv;
                            d.done = 1'b1;
                        end
                    end else begin
                        d.upd_cv = req_oh;
                        if (victim_live) begin
                            d.state     = ST_EVICT;
                            d.pend      = rd_cv;
                            d.snp_valid = 1'b1;
                            d.snp_mask  = rd_cv;
                            d.snp_addr  = {rd_tag, req_addr[IDX_W-1:0]};
                            d.snp_inval = 1'b1;
                        end else begin
                            d.state   = ST_MEM;
                            d.mem_req = 1'b1;
                        end
                    end
                end
            end
            ST_SNOOP: begin
                d.pend = pend_left;
                if (pend_left == '0) begin
                    wr_en   = 1'b1;
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end
            end
            ST_EVICT: begin
                d.pend = pend_left;
                if (pend_left == '0) begin
                    d.mem_req = 1'b1;
                    d.state   = ST_MEM;
                end
            end
            ST_MEM: begin
                if (mem_fill) begin
                    wr_en   = 1'b1;
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.state != ST_IDLE);
    assign snp_valid = q.snp_valid;
    assign snp_mask  = q.snp_mask;
    assign snp_addr  = q.snp_addr;
    assign snp_inval = q.snp_inval;
    assign mem_req   = q.mem_req;
    assign mem_addr  = q.addr;
    assign done      = q.done;

    logic [NUM_CORES-1:0] q_req_oh;
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_qoh
        assign q_req_oh[c] = (q.core == CORE_W'(c));
    end

    a_r1_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({snp_valid, mem_req, done}));

    a_r2_miss_goes_to_memory: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !hit && !victim_live) |=> (mem_req && !snp_valid && busy));

    a_r3_private_hit_no_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit && ((rd_cv & ~req_oh) == '0)) |=> (done && !snp_valid && !mem_req));

    a_r5_shared_read_no_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit && !req_own && ($countones(rd_cv) > 1)) |=> (done && !snp_valid));

    a_r6_requester_not_snooped: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && (q.state == ST_SNOOP)) |-> ((snp_mask & q_req_oh) == '0));

    a_r7_evict_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && (q.state == ST_EVICT)) |-> (snp_inval && (snp_mask != '0)));

    a_r8_wait_all_responses: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_SNOOP) && (pend_left != '0)) |=> (busy && !done));

    a_r8_done_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/test_incl_snoop_ctrl.sv
module test_incl_snoop_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_core = '0;
    logic [11:0] req_addr = '0;
    logic       req_own = 1'b0;
    logic       busy, snp_valid, snp_inval, mem_req, done;
    logic [3:0] snp_mask;
    logic [11:0] snp_addr, mem_addr;
    logic [3:0] snp_resp = '0;
    logic       mem_fill = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    incl_snoop_ctrl i_incl_snoop_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_core(req_core), .req_addr(req_addr), .req_own(req_own),
        .busy(busy),
        .snp_valid(snp_valid), .snp_mask(snp_mask), .snp_addr(snp_addr), .snp_inval(snp_inval),
        .snp_resp(snp_resp),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_fill(mem_fill),
        .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] core, input logic [11:0] addr, input logic own);
        req_valid = 1'b1; req_core = core; req_addr = addr; req_own = own;
        step();
        req_valid = 1'b0;
    endtask

    task automatic respond(input logic [3:0] m);
        snp_resp = m;
        step();
        snp_resp = '0;
    endtask

    task automatic fill();
        mem_fill = 1'b1;
        step();
        mem_fill = 1'b0;
    endtask

    task automatic expect_snoop(input string req, input logic [3:0] m,
                                input logic inv, input logic [11:0] a);
        check(snp_valid == 1'b1, req, "snp_valid", snp_valid, 1);
        check(snp_mask == m, req, "snp_mask", snp_mask, m);
        check(snp_inval == inv, req, "snp_inval", snp_inval, inv);
        check(snp_addr == a, req, "snp_addr", snp_addr, a);
        check(busy == 1'b1, req, "busy", busy, 1);
    endtask

    task automatic t_reset();
        check(!busy && !snp_valid && !mem_req && !done, "R1", "idle outputs",
              {busy, snp_valid, mem_req, done}, 0);
    endtask

    task automatic t_cold_miss();
        issue(2'd0, 12'h010, 1'b0);
        check(mem_req == 1'b1, "R2", "mem_req", mem_req, 1);
        check(mem_addr == 12'h010, "R2", "mem_addr", mem_addr, 12'h010);
        check(snp_valid == 1'b0, "R2", "no snoop", snp_valid, 0);
        req_valid = 1'b1; req_core = 2'd1; req_addr = 12'h011; req_own = 1'b0;
        step();
        step();
        check(busy && !mem_req && !done, "R8", "request while busy",
              {busy, mem_req, done}, 3'b100);
        req_valid = 1'b0;
        fill();
        check(done == 1'b1 && busy == 1'b0, "R2", "done after fill", {done, busy}, 2'b10);
        step();
        check(!mem_req && !snp_valid && !busy, "R8", "dropped request not served",
              {mem_req, snp_valid, busy}, 0);
    endtask

    task automatic t_single_owner();
        issue(2'd1, 12'h010, 1'b0);
        expect_snoop("R4", 4'b0001, 1'b0, 12'h010);
        respond(4'b0001);
        check(done == 1'b1 && busy == 1'b0, "R4", "done after response", {done, busy}, 2'b10);
    endtask

    task automatic t_shared_read();
        issue(2'd2, 12'h010, 1'b0);
        check(snp_valid == 1'b0, "R5", "no snoop on shared", snp_valid, 0);
        check(done == 1'b1 && !busy && !mem_req, "R5", "immediate done",
              {done, busy, mem_req}, 3'b100);
    endtask

    task automatic t_rfo_hit();
        issue(2'd3, 12'h010, 1'b1);
        expect_snoop("R6", 4'b0111, 1'b1, 12'h010);
        respond(4'b0001);
        check(busy == 1'b1 && done == 1'b0, "R8", "partial response", {busy, done}, 2'b10);
        respond(4'b0110);
        check(done == 1'b1 && busy == 1'b0, "R6", "done after all", {done, busy}, 2'b10);
        issue(2'd0, 12'h010, 1'b0);
        expect_snoop("R6", 4'b1000, 1'b0, 12'h010);
        respond(4'b1000);
        check(done == 1'b1, "R9", "probe completes", done, 1);
    endtask

    task automatic t_private_hit();
        issue(2'd1, 12'h011, 1'b0);
        check(mem_req == 1'b1 && !snp_valid, "R2", "second set miss", {mem_req, snp_valid}, 2'b10);
        fill();
        check(done == 1'b1, "R9", "fill done", done, 1);
        issue(2'd1, 12'h011, 1'b1);
        check(done && !snp_valid && !mem_req && !busy, "R3", "own-only hit",
              {done, snp_valid, mem_req, busy}, 4'b1000);
    endtask

    task automatic t_evict();
        issue(2'd2, 12'h018, 1'b0);
        expect_snoop("R7", 4'b1001, 1'b1, 12'h010);
        check(mem_req == 1'b0, "R7", "no memory before responses", mem_req, 0);
        respond(4'b0001);
        check(mem_req == 1'b0 && busy, "R7", "still waiting", {mem_req, busy}, 2'b01);
        respond(4'b1000);
        check(mem_req == 1'b1, "R7", "mem_req after back-invalidate", mem_req, 1);
        check(mem_addr == 12'h018, "R7", "mem_addr", mem_addr, 12'h018);
        fill();
        check(done == 1'b1 && !busy, "R7", "done", {done, busy}, 2'b10);
        issue(2'd0, 12'h018, 1'b0);
        expect_snoop("R9", 4'b0100, 1'b0, 12'h018);
        respond(4'b0100);
        check(done == 1'b1, "R9", "done", done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_cold_miss();
        t_single_owner();
        t_shared_read();
        t_rfo_hit();
        t_private_hit();
        t_evict();
        step();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule